// File: doc/BRIEF.md
# Replica-Path Voltage Margin Probe

This block measures how much voltage margin a single comparator of a selection-based decision path has, while live traffic keeps flowing. The main receiver path produces one decision per interleaved lane each cycle. The probe rebuilds, for one chosen lane, the same decision history the main path uses. That history indexes a static pattern-to-comparator assignment table. When the history routes the bit to the comparator under test, the replica path uses a spare comparator's output in place of the real one. The replica decision is XORed with the main decision, and each mismatch is counted as a pseudo error.

Only bits whose history selects the targeted comparator can produce an error, because the assignment table filters out every other pattern. No known test pattern is needed. Outside software sweeps the spare threshold, the target and the lane, and reads the count after each window to build the full margin map.

A start pulse opens a window. It clears the count and captures the target comparator and lane. The window then counts for a programmed number of bit times. When it closes, a one-cycle done pulse is raised and the count is held until the next start.

Top module: `margin_probe`

## Requirements
- R1: After reset, `err_count_o` is 0 and `done_o` is 0.
- R2: A cycle with `start_i` high clears the count. `err_count_o` reads 0 in the following cycle. The same edge captures `tgt_i` and `lane_i`, and later changes to those inputs have no effect until the next start.
- R3: For the captured lane L, bit n is `dec_i[L]` of the current cycle. The bit just before lane L is lane L-1 of the same cycle. The bit just before lane 0 is lane LANES-1 of the previous cycle. The history index is made of the 3 bits before bit n, with the most recent bit as the MSB. Entry p of `map_i` sits at bits [3p+2:3p].
- R4: In a counted cycle, when the history entry names the captured target and `spare_i` differs from `dec_i[L]`, the count rises by one.
- R5: When the history entry names any other comparator, the cycle adds nothing, whatever `spare_i` is.
- R6: The cycles counted are exactly the `win_len_i` cycles that follow the start cycle (a length of 0 acts as 1). `done_o` is high for exactly the one cycle after the last counted cycle.
- R7: Between the end of a window and the next start, `err_count_o` does not change.
- R8: The count stops at 2047 and never wraps.
- R9: A start inside an open window abandons that window. The count restarts from 0, and done follows only the new window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a measurement window |
| win_len_i | input | 12 | Window length in bit times, sampled at start |
| tgt_i | input | 3 | Comparator under test, sampled at start |
| lane_i | input | 2 | Interleaved lane to probe, sampled at start |
| map_i | input | 24 | Static history-pattern to comparator table, 3 bits per pattern |
| dec_i | input | 4 | Main-path decisions, lane 0 earliest in time |
| spare_i | input | 1 | Spare comparator bit for the probed lane |
| err_count_o | output | 11 | Saturating pseudo-error count |
| done_o | output | 1 | One-cycle pulse at window end |

## Verification
The assertions assume that `start_i` is a synchronous pulse and that `map_i` stays fixed during a window. They also assume that the main decisions arrive in a steady lane order, so that an error can only come from a counted cycle. The stimulus changes the table, target and lane only at window boundaries or with a fresh start. Decisions and spare bits are drawn freely, because any bit values are legal. The one deliberate exception is the latching test, which changes the target and lane inputs in the middle of a window. It shows that this change has no effect, and no assertion depends on those inputs.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_RUN = 1'b1} win_state_e;
endpackage

// File: rtl/mr_hist_sel.sv
module mr_hist_sel #(
  parameter int LANES = 4,
  parameter int TAPS  = 3,
  parameter int IDXW  = 3,
  localparam int LW   = $clog2(LANES),
  localparam int NPAT = 1 << TAPS,
  localparam int SBW  = $clog2(2 * LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       dec_i,
  input  logic [LW-1:0]          lane_i,
  input  logic [NPAT*IDXW-1:0]   map_i,
  output logic [IDXW-1:0]        sel_o,
  output logic                   bit_o
);
  logic [LANES-1:0]   prev_q, prev_d;
  logic [2*LANES-1:0] stream;
  logic [TAPS-1:0]    pat;

  // previous cycle's decisions form the older half of the serial stream
  always_comb prev_d = dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    int pos;
    stream = {dec_i, prev_q};
    pat    = '0;
    for (int j = 1; j <= TAPS; j++) begin
      pos = LANES + int'(lane_i) - j;
      pat[TAPS-j] = stream[pos[SBW-1:0]];
    end
  end

  always_comb begin
    sel_o = map_i[int'(pat)*IDXW +: IDXW];
    bit_o = dec_i[lane_i];
  end
endmodule

// File: rtl/mr_window.sv
module mr_window #(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             active_o,
  output logic             done_o
);
  import mr_pkg::*;

  win_state_e       state_q, state_d;
  logic [WIN_W-1:0] rem_q, rem_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    if (start_i) begin
      state_d = WIN_RUN;
      rem_d   = len_i;
    end else if (state_q == WIN_RUN) begin
      if (rem_q <= WIN_W'(1)) begin
        state_d = WIN_IDLE;
        done_d  = 1'b1;
      end else begin
        rem_d = rem_q - WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  assign active_o = (state_q == WIN_RUN);
  assign done_o   = done_q;
endmodule

// File: rtl/mr_sat_cnt.sv
module mr_sat_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                    cnt_d = '0;
    else if (inc_i && cnt_q != TOP) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/margin_probe.sv
module margin_probe #(
  parameter int LANES = 4,
  parameter int TAPS  = 3,
  parameter int COMPS = 6,
  parameter int CNT_W = 11,
  parameter int WIN_W = 12,
  localparam int IDXW = $clog2(COMPS),
  localparam int LW   = $clog2(LANES),
  localparam int NPAT = 1 << TAPS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [WIN_W-1:0]     win_len_i,
  input  logic [IDXW-1:0]      tgt_i,
  input  logic [LW-1:0]        lane_i,
  input  logic [NPAT*IDXW-1:0] map_i,
  input  logic [LANES-1:0]     dec_i,
  input  logic                 spare_i,
  output logic [CNT_W-1:0]     err_count_o,
  output logic                 done_o
);
  logic [IDXW-1:0] tgt_q, tgt_d;
  logic [LW-1:0]   lane_q, lane_d;
  logic [IDXW-1:0] sel;
  logic            main_bit;
  logic            win_active;
  logic            pseudo_err;

  always_comb begin
    tgt_d  = start_i ? tgt_i  : tgt_q;
    lane_d = start_i ? lane_i : lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      lane_q <= '0;
    end else begin
      tgt_q  <= tgt_d;
      lane_q <= lane_d;
    end
  end

  mr_hist_sel #(.LANES(LANES), .TAPS(TAPS), .IDXW(IDXW)) u_hist (
    .clk(clk), .rst_n(rst_n), .dec_i(dec_i), .lane_i(lane_q),
    .map_i(map_i), .sel_o(sel), .bit_o(main_bit)
  );

  mr_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(win_len_i),
    .active_o(win_active), .done_o(done_o)
  );

  // replica differs from main only where the spare stands in for the target
  always_comb pseudo_err = win_active && !start_i && (sel == tgt_q) && (spare_i ^ main_bit);

  mr_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .inc_i(pseudo_err),
    .cnt_o(err_count_o)
  );
endmodule

// File: rtl/margin_probe_chk.sv
module margin_probe_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic             win_active,
  input logic [CNT_W-1:0] err_count_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (err_count_o == '0));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (err_count_o == $past(err_count_o) || err_count_o == $past(err_count_o) + CNT_W'(1)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !win_active);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_active && !start_i) |=> $stable(err_count_o));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count_o == TOP && !start_i) |=> (err_count_o == TOP));
endmodule

bind margin_probe margin_probe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .win_active(win_active), .err_count_o(err_count_o)
);

// File: tb/tb_margin_probe.sv
module tb_margin_probe;
  localparam int LANES = 4;
  localparam int TAPS  = 3;
  localparam int IDXW  = 3;
  localparam int MAXC  = 2047;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [11:0] win_len;
  logic [2:0]  tgt;
  logic [1:0]  lane;
  logic [23:0] map;
  logic [3:0]  dec;
  logic        spare;
  logic [10:0] err_count;
  logic        done;

  int nchk = 0, nerr = 0;
  int m_cnt, m_rem, m_tgt, m_lane;
  bit m_done, m_active;
  bit [3:0] m_prev;

  always #5 clk = ~clk;

  margin_probe dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .win_len_i(win_len),
    .tgt_i(tgt), .lane_i(lane), .map_i(map), .dec_i(dec), .spare_i(spare),
    .err_count_o(err_count), .done_o(done)
  );

  task automatic check(string req, string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int pattern_of(bit [3:0] d, bit [3:0] p, int ln);
    bit [7:0] s = {d, p};
    int r = 0;
    for (int j = 1; j <= TAPS; j++) r = (r << 1) | int'(s[LANES + ln - j]);
    return r;
  endfunction

  task automatic model_step();
    int comp = int'((map >> (pattern_of(dec, m_prev, m_lane) * IDXW)) & 24'h7);
    bit nd = 1'b0;
    if (start) begin
      m_cnt = 0; m_tgt = int'(tgt); m_lane = int'(lane);
      m_active = 1'b1; m_rem = int'(win_len);
    end else if (m_active) begin
      if (comp == m_tgt && spare != dec[m_lane] && m_cnt < MAXC) m_cnt++;
      if (m_rem <= 1) begin m_active = 1'b0; nd = 1'b1; end
      else m_rem--;
    end
    m_prev = dec;
    m_done = nd;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, "count", int'(err_count), m_cnt);
    check(tag, "done", int'(done), int'(m_done));
  endtask

  task automatic go(int t, int l, int w);
    start = 1'b1; tgt = 3'(t); lane = 2'(l); win_len = 12'(w);
    cyc("R2");
    start = 1'b0;
    check("R2", "cleared count", int'(err_count), 0);
  endtask

  task automatic err_cycles(int n, int ln, string tag);
    for (int i = 0; i < n; i++) begin
      dec = 4'($urandom); spare = ~dec[ln];
      cyc(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; win_len = '0; tgt = '0; lane = '0;
    map = '0; dec = '0; spare = 1'b0;
    m_cnt = 0; m_rem = 0; m_tgt = 0; m_lane = 0; m_done = 0; m_active = 0; m_prev = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset count", int'(err_count), 0);
    check("R1", "reset done", int'(done), 0);
    rst_n = 1'b1;
    cyc("R1");

    // R5: history never names the target
    map = {8{3'd5}};
    go(2, 1, 20);
    err_cycles(20, 1, "R5");
    check("R5", "filtered count", int'(err_count), 0);
    check("R6", "done at end", int'(done), 1);

    // R4: every bit routed to target, all mismatching
    map = {8{3'd3}};
    go(3, 2, 25);
    err_cycles(25, 2, "R4");
    check("R4", "all errors", int'(err_count), 25);
    check("R6", "done at end", int'(done), 1);

    // R7: hold after window
    err_cycles(10, 2, "R7");
    check("R7", "held count", int'(err_count), 25);

    // R3: only history 100 (most recent = 1) maps to comparator 1
    map = 24'h001000;
    dec = 4'b1000; spare = 1'b1;
    go(1, 0, 16);
    for (int i = 0; i < 16; i++) cyc("R3");
    check("R3", "lane0 order", int'(err_count), 16);
    dec = 4'b0010;
    go(1, 2, 12);
    for (int i = 0; i < 12; i++) cyc("R3");
    check("R3", "lane2 order", int'(err_count), 12);
    dec = 4'b1000;
    go(1, 1, 12);
    for (int i = 0; i < 12; i++) cyc("R3");
    check("R3", "lane1 miss", int'(err_count), 0);

    // R6: zero length acts as one
    map = '0;
    go(0, 0, 0);
    err_cycles(1, 0, "R6");
    check("R6", "zero len count", int'(err_count), 1);
    check("R6", "zero len done", int'(done), 1);

    // R8: saturation
    go(0, 0, 2100);
    err_cycles(2100, 0, "R8");
    check("R8", "saturated", int'(err_count), MAXC);

    // R9: restart mid window
    go(0, 1, 40);
    err_cycles(10, 1, "R9");
    go(0, 1, 15);
    err_cycles(15, 1, "R9");
    check("R9", "restart count", int'(err_count), 15);
    check("R9", "restart done", int'(done), 1);

    // R2: later changes to target/lane inputs ignored
    map = {8{3'd4}};
    go(4, 3, 10);
    tgt = 3'd0; lane = 2'd0;
    err_cycles(10, 3, "R2");
    check("R2", "latched target", int'(err_count), 10);

    // random windows against the model
    for (int k = 0; k < 30; k++) begin
      map = 24'($urandom);
      go(int'($urandom_range(0, 5)), int'($urandom_range(0, 3)), int'($urandom_range(1, 40)));
      for (int i = 0; i < 45; i++) begin
        dec = 4'($urandom); spare = 1'($urandom);
        cyc("R4");
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule